// File: doc/BRIEF.md
# DRAM Burst Refresh and Self-Refresh Sequencer

This block is the refresh engine of an asynchronous DRAM controller. When the host asks for self refresh, it runs a full burst of refresh cycles, puts the memory into self refresh, and holds it there. When the host asks to wake, it brings the memory out and runs a second full burst. Every row is therefore refreshed on both sides of the self-refresh interval. Burst cycles use one of two forms. In CAS-before-RAS form the device supplies its own row. In RAS-only form the block drives a wrapping row counter onto the address pins.

Three windows are measured in clock cycles. The entry window runs from the first burst RAS fall to the RAS fall that starts self refresh. The exit window runs from the RAS rise that ends self refresh to the RAS fall of the last exit-burst cycle. The third window is their sum. If any of these would pass its parameter limit, a sticky error flag is raised. Normal read/write traffic may use the memory only while the grant output is high. The grant is a ready signal without a valid partner: a host transfer happens in a cycle where the host wants access and the grant is high. The grant falls in the same cycle that a self-refresh request is raised, and it stays low until the exit burst has finished.

Top module: `rfsh_seq_top`

## Requirements
- R1: After reset: ras_n=1, cas_n=1, row_addr=0, acc_ready=1 (with sr_req low), sr_active=0, err=0.
- R2: acc_ready is high only while the sequencer is idle and sr_req is low. A raised sr_req drops acc_ready combinationally in the same cycle. acc_ready stays low at every RAS fall of a sequence.
- R3: A sequence starts on a clock edge that samples sr_req high in idle. It begins with an entry burst of 2^ROW_BITS refresh cycles. Each cycle is one setup clock with RAS high, then T_ACT clocks with RAS low, then T_PRE clocks with RAS high.
- R4: With row_mode=0 (CAS-before-RAS), cas_n is low during the setup clock and the RAS-low clocks of each burst cycle, so CAS falls at least one clock before RAS.
- R5: With row_mode=1 (RAS-only), cas_n stays high for the whole burst. row_addr holds a row during each RAS-low phase and then advances by one, wrapping from 2^ROW_BITS-1 to 0.
- R6: After the entry burst there is one clock with cas_n low and RAS high. Then both go low and sr_active is high. RAS then stays low for at least T_RASS clocks.
- R7: A wake_req pulse taken during self refresh ends it. If the pulse comes early, RAS is held low for exactly T_RASS clocks. If it comes later, RAS rises on the edge that samples the pulse. After one clock with both strobes high, an exit burst of 2^ROW_BITS cycles runs and the block returns to idle.
- R8: The row counter keeps its value across self refresh and across sequences, so the exit burst continues the row order where the entry burst stopped.
- R9: err is raised if the entry window (clocks from the first burst RAS fall to the self-refresh RAS fall) exceeds T_NSB.
- R10: err is raised if the exit window (clocks from the self-refresh RAS rise to the last exit-burst RAS fall) exceeds T_SNB.
- R11: err is raised if the entry window plus the exit window exceeds T_RET.
- R12: err stays high until reset.
- R13: row_mode is sampled only when a sequence starts. Changing it later has no effect on that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sr_req | input | 1 | Request to enter self refresh, sampled in idle |
| wake_req | input | 1 | Request to leave self refresh, a pulse or a level |
| row_mode | input | 1 | Burst form: 0 = CAS-before-RAS, 1 = RAS-only |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| row_addr | output | ROW_BITS | Row address for RAS-only cycles |
| acc_ready | output | 1 | Read/write access grant |
| sr_active | output | 1 | High while the memory is held in self refresh |
| err | output | 1 | Sticky refresh-window violation |

## Verification
A corrupted phase counter or state shows up at the strobes within one refresh cycle. It appears as a RAS-low run of the wrong length, a wrong count of high clocks before the next fall, or a CAS level that does not match the mode. A slipped or reset row counter shows up on row_addr at the very next RAS fall. It is easiest to see at the self-refresh fall and at the first exit fall, where the value must carry over. A window counter that is off by one is visible on err only at the boundary. For that reason, instances with limits exactly at the measured window lengths and one clock below them are compared side by side.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_SETUP    = 3'd1,
    ST_ACT      = 3'd2,
    ST_PRE      = 3'd3,
    ST_SR_SETUP = 3'd4,
    ST_SR_HOLD  = 3'd5,
    ST_SR_EXIT  = 3'd6
  } rfsh_st_e;

  typedef enum logic {
    MODE_CBR = 1'b0,
    MODE_ROW = 1'b1
  } rfsh_mode_e;

  function automatic logic st_ras_low(input rfsh_st_e s);
    return (s == ST_ACT) || (s == ST_SR_HOLD);
  endfunction

  function automatic logic st_cas_low(input rfsh_st_e s, input rfsh_mode_e m);
    return (s == ST_SR_SETUP) || (s == ST_SR_HOLD) ||
           ((m == MODE_CBR) && ((s == ST_SETUP) || (s == ST_ACT)));
  endfunction

endpackage

// File: rtl/rfsh_row_ctr.sv
module rfsh_row_ctr #(
  parameter int ROW_BITS = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv,
  output logic [ROW_BITS-1:0] row
);
  localparam logic [ROW_BITS-1:0] ROW_MAX = {ROW_BITS{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   row <= '0;
    else if (adv) row <= row + 1'b1;
  end

  // R5
  row_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && row == ROW_MAX) |=> (row == '0));

  // R8
  row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(row));

endmodule

// File: rtl/rfsh_win_meter.sv
module rfsh_win_meter #(
  parameter int W     = 24,
  parameter int LIMIT = 1000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         stop,
  output logic         run,
  output logic [W-1:0] cnt,
  output logic [W-1:0] len,
  output logic         over
);
  localparam logic [W-1:0] LIM     = W'(LIMIT);
  localparam logic [W-1:0] CNT_TOP = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      cnt <= '0;
      len <= '0;
    end else if (start) begin
      run <= 1'b1;
      cnt <= '0;
    end else if (run) begin
      if (stop) begin
        run <= 1'b0;
        len <= cnt + 1'b1;
      end else if (cnt != CNT_TOP) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // elapsed clocks at the next edge would be cnt+1
  assign over = run && (cnt >= LIM);

  // R9
  stop_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |-> run);

endmodule

// File: rtl/rfsh_phase_fsm.sv
module rfsh_phase_fsm
  import rfsh_pkg::*;
#(
  parameter int ROW_BITS = 10,
  parameter int T_ACT    = 6,
  parameter int T_PRE    = 4,
  parameter int T_RASS   = 12500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sr_req,
  input  logic       wake_req,
  input  logic       row_mode,
  output rfsh_st_e   st,
  output rfsh_mode_e mode_q,
  output logic       row_adv,
  output logic       nsb_start,
  output logic       nsb_stop,
  output logic       snb_start,
  output logic       snb_stop
);
  localparam int PH_MAX = (T_ACT > T_PRE) ? T_ACT : T_PRE;
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int RS_W   = $clog2(T_RASS + 1);
  localparam logic [PH_W-1:0]     ACT_LAST = PH_W'(T_ACT - 1);
  localparam logic [PH_W-1:0]     PRE_LAST = PH_W'(T_PRE - 1);
  localparam logic [RS_W-1:0]     RS_LAST  = RS_W'(T_RASS - 1);
  localparam logic [ROW_BITS-1:0] REF_LAST = {ROW_BITS{1'b1}};

  rfsh_st_e            nxt;
  logic [PH_W-1:0]     ph;
  logic [RS_W-1:0]     rass_cnt;
  logic [ROW_BITS-1:0] ref_cnt;
  logic                exit_q;
  logic                wake_pend;
  logic                last_ref;
  logic                rass_ok;

  assign last_ref = (ref_cnt == REF_LAST);
  assign rass_ok  = (rass_cnt >= RS_LAST);

  always_comb begin
    nxt = st;
    unique case (st)
      ST_IDLE:     if (sr_req) nxt = ST_SETUP;
      ST_SETUP:    nxt = ST_ACT;
      ST_ACT:      if (ph == ACT_LAST) nxt = ST_PRE;
      ST_PRE: begin
        if (ph == PRE_LAST) begin
          if (!last_ref)   nxt = ST_SETUP;
          else if (exit_q) nxt = ST_IDLE;
          else             nxt = ST_SR_SETUP;
        end
      end
      ST_SR_SETUP: nxt = ST_SR_HOLD;
      ST_SR_HOLD:  if (rass_ok && (wake_pend || wake_req)) nxt = ST_SR_EXIT;
      ST_SR_EXIT:  nxt = ST_SETUP;
      default:     nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      ph        <= '0;
      rass_cnt  <= '0;
      ref_cnt   <= '0;
      exit_q    <= 1'b0;
      wake_pend <= 1'b0;
      mode_q    <= MODE_CBR;
    end else begin
      st <= nxt;
      ph <= (nxt != st) ? '0 : ph + 1'b1;
      if (st == ST_IDLE && sr_req) begin
        mode_q  <= rfsh_mode_e'(row_mode);
        exit_q  <= 1'b0;
        ref_cnt <= '0;
      end
      if (st == ST_PRE && ph == PRE_LAST && !last_ref) ref_cnt <= ref_cnt + 1'b1;
      if (st == ST_SR_SETUP) rass_cnt <= '0;
      else if (st == ST_SR_HOLD && !rass_ok) rass_cnt <= rass_cnt + 1'b1;
      if ((st == ST_SR_SETUP || st == ST_SR_HOLD) && wake_req) wake_pend <= 1'b1;
      if (st == ST_SR_EXIT) begin
        wake_pend <= 1'b0;
        exit_q    <= 1'b1;
        ref_cnt   <= '0;
      end
    end
  end

  assign row_adv   = (st == ST_ACT) && (ph == ACT_LAST) && (mode_q == MODE_ROW);
  assign nsb_start = (st == ST_SETUP) && !exit_q && (ref_cnt == '0);
  assign nsb_stop  = (st == ST_SR_SETUP);
  assign snb_start = (st == ST_SR_HOLD) && (nxt == ST_SR_EXIT);
  assign snb_stop  = (st == ST_SETUP) && exit_q && last_ref;

  // R13
  mode_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE) |=> $stable(mode_q));

  // R3
  setup_to_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SETUP) |=> (st == ST_ACT));

endmodule

// File: rtl/rfsh_seq_top.sv
module rfsh_seq_top
  import rfsh_pkg::*;
#(
  parameter int ROW_BITS = 10,
  parameter int T_ACT    = 6,
  parameter int T_PRE    = 4,
  parameter int T_RASS   = 12500,
  parameter int T_NSB    = 2050000,
  parameter int T_SNB    = 2050000,
  parameter int T_RET    = 2050000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sr_req,
  input  logic                wake_req,
  input  logic                row_mode,
  output logic                ras_n,
  output logic                cas_n,
  output logic [ROW_BITS-1:0] row_addr,
  output logic                acc_ready,
  output logic                sr_active,
  output logic                err
);
  localparam int WIN_W = $clog2(T_NSB + T_SNB + T_RET + 2);
  localparam int SL_W  = $clog2(T_RASS + 1);
  localparam logic [WIN_W:0]  RET_LIM = (WIN_W + 1)'(T_RET);
  localparam logic [SL_W-1:0] RASS_L  = SL_W'(T_RASS);

  rfsh_st_e         st;
  rfsh_mode_e       mode_q;
  logic             row_adv, nsb_start, nsb_stop, snb_start, snb_stop;
  logic             run_n, run_s, over_n, over_s, sum_over, err_q;
  logic [WIN_W-1:0] cnt_n, len_n, cnt_s, len_s;
  logic [WIN_W:0]   sum_w;

  rfsh_phase_fsm #(
    .ROW_BITS(ROW_BITS), .T_ACT(T_ACT), .T_PRE(T_PRE), .T_RASS(T_RASS)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .sr_req(sr_req), .wake_req(wake_req),
    .row_mode(row_mode), .st(st), .mode_q(mode_q), .row_adv(row_adv),
    .nsb_start(nsb_start), .nsb_stop(nsb_stop),
    .snb_start(snb_start), .snb_stop(snb_stop)
  );

  rfsh_row_ctr #(.ROW_BITS(ROW_BITS)) u_row (
    .clk(clk), .rst_n(rst_n), .adv(row_adv), .row(row_addr)
  );

  rfsh_win_meter #(.W(WIN_W), .LIMIT(T_NSB)) u_nsb (
    .clk(clk), .rst_n(rst_n), .start(nsb_start), .stop(nsb_stop),
    .run(run_n), .cnt(cnt_n), .len(len_n), .over(over_n)
  );

  rfsh_win_meter #(.W(WIN_W), .LIMIT(T_SNB)) u_snb (
    .clk(clk), .rst_n(rst_n), .start(snb_start), .stop(snb_stop),
    .run(run_s), .cnt(cnt_s), .len(len_s), .over(over_s)
  );

  // entry length plus exit elapsed at the next edge (cnt_s+1) must stay within T_RET
  assign sum_w    = {1'b0, len_n} + {1'b0, cnt_s};
  assign sum_over = run_s && (sum_w >= RET_LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_q | over_n | over_s | sum_over;
  end

  assign err       = err_q;
  assign ras_n     = !st_ras_low(st);
  assign cas_n     = !st_cas_low(st, mode_q);
  assign sr_active = (st == ST_SR_HOLD);
  assign acc_ready = (st == ST_IDLE) && !sr_req;

  logic [SL_W-1:0] sr_lo_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               sr_lo_cnt <= '0;
    else if (!sr_active)                      sr_lo_cnt <= '0;
    else if (sr_lo_cnt != RASS_L)             sr_lo_cnt <= sr_lo_cnt + 1'b1;
  end

  // R6
  sr_min_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr_active) |-> (sr_lo_cnt == RASS_L));

  // R4
  cas_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && (mode_q == MODE_CBR || sr_active)) |-> !$past(cas_n));

  // R5
  rasonly_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_ROW && (st == ST_SETUP || st == ST_ACT || st == ST_PRE)) |-> cas_n);

  // R2
  grant_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ready |-> (ras_n && cas_n));

  // R12
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

endmodule

// File: tb/rfsh_seq_top_bench.sv
module rfsh_seq_top_bench;
  localparam int RB = 3;
  localparam int NR = 1 << RB;
  localparam int TA = 2;
  localparam int TP = 2;
  localparam int TR = 20;
  localparam int CYC = 1 + TA + TP;
  localparam int NSB_LEN = TA + TP + (NR - 1) * CYC + 1;
  localparam int SNB_LEN = 1 + (NR - 1) * CYC + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sr_req = 1'b0, wake_req = 1'b0, row_mode = 1'b0;
  always #4 clk = ~clk;

  logic          ras_n, cas_n, acc_ready, sr_active, err;
  logic [RB-1:0] row_addr;
  logic          a_ras, a_cas, a_rdy, a_sra, a_err;
  logic          b_ras, b_cas, b_rdy, b_sra, b_err;
  logic          c_ras, c_cas, c_rdy, c_sra, c_err;
  logic [RB-1:0] a_row, b_row, c_row;

  rfsh_seq_top #(.ROW_BITS(RB), .T_ACT(TA), .T_PRE(TP), .T_RASS(TR),
    .T_NSB(NSB_LEN), .T_SNB(SNB_LEN), .T_RET(NSB_LEN + SNB_LEN)) u_rfsh_seq_top (
    .clk(clk), .rst_n(rst_n), .sr_req(sr_req), .wake_req(wake_req), .row_mode(row_mode),
    .ras_n(ras_n), .cas_n(cas_n), .row_addr(row_addr), .acc_ready(acc_ready),
    .sr_active(sr_active), .err(err));

  rfsh_seq_top #(.ROW_BITS(RB), .T_ACT(TA), .T_PRE(TP), .T_RASS(TR),
    .T_NSB(NSB_LEN - 1), .T_SNB(1000), .T_RET(5000)) u_tight_nsb (
    .clk(clk), .rst_n(rst_n), .sr_req(sr_req), .wake_req(wake_req), .row_mode(row_mode),
    .ras_n(a_ras), .cas_n(a_cas), .row_addr(a_row), .acc_ready(a_rdy),
    .sr_active(a_sra), .err(a_err));

  rfsh_seq_top #(.ROW_BITS(RB), .T_ACT(TA), .T_PRE(TP), .T_RASS(TR),
    .T_NSB(1000), .T_SNB(SNB_LEN - 1), .T_RET(5000)) u_tight_snb (
    .clk(clk), .rst_n(rst_n), .sr_req(sr_req), .wake_req(wake_req), .row_mode(row_mode),
    .ras_n(b_ras), .cas_n(b_cas), .row_addr(b_row), .acc_ready(b_rdy),
    .sr_active(b_sra), .err(b_err));

  rfsh_seq_top #(.ROW_BITS(RB), .T_ACT(TA), .T_PRE(TP), .T_RASS(TR),
    .T_NSB(1000), .T_SNB(1000), .T_RET(NSB_LEN + SNB_LEN - 1)) u_tight_sum (
    .clk(clk), .rst_n(rst_n), .sr_req(sr_req), .wake_req(wake_req), .row_mode(row_mode),
    .ras_n(c_ras), .cas_n(c_cas), .row_addr(c_row), .acc_ready(c_rdy),
    .sr_active(c_sra), .err(c_err));

  typedef struct {
    int    kind;
    int    row;
    int    gap;
    int    lo_min;
    int    lo_max;
    int    cas;
    string tg;
  } exp_t;

  exp_t q[$];
  int total = 0, bad = 0, row_model = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops one expected item per RAS fall, closes it at the RAS rise
  initial begin
    logic pr_ras, pr_cas;
    int   lo, hi;
    bit   open;
    exp_t cur;
    pr_ras = 1'b1; pr_cas = 1'b1; lo = 0; hi = 0; open = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        pr_ras = 1'b1; pr_cas = 1'b1; lo = 0; hi = 0; open = 0;
      end else begin
        if (pr_ras && !ras_n) begin
          if (q.size() == 0) chk(0, "R3", 1, 0);
          else begin
            cur  = q.pop_front();
            open = 1;
            chk(int'(row_addr) == cur.row, "R8", int'(row_addr), cur.row);
            chk(int'(pr_cas) == cur.cas && int'(cas_n) == cur.cas, cur.tg, int'(pr_cas), cur.cas);
            chk(int'(sr_active) == (cur.kind == 1 ? 1 : 0), "R6", int'(sr_active), cur.kind);
            chk(acc_ready == 1'b0, "R2", int'(acc_ready), 0);
            if (cur.gap > 0) chk(hi == cur.gap, "R3", hi, cur.gap);
          end
          lo = 1;
        end else if (!pr_ras && ras_n) begin
          if (open) chk(lo >= cur.lo_min && lo <= cur.lo_max, (cur.kind == 1) ? "R7" : "R3", lo, cur.lo_min);
          open = 0;
          hi = 1;
        end else if (!ras_n) lo++;
        else hi++;
        pr_ras = ras_n;
        pr_cas = cas_n;
      end
    end
  end

  task automatic push_burst(input bit rm, input int first_gap, input bit flip);
    for (int i = 0; i < NR; i++) begin
      exp_t e;
      e.kind = 0; e.row = row_model; e.gap = (i == 0) ? first_gap : 3;
      e.lo_min = TA; e.lo_max = TA; e.cas = rm ? 1 : 0;
      e.tg = flip ? "R13" : (rm ? "R5" : "R4");
      q.push_back(e);
      if (rm) row_model = (row_model + 1) % NR;
    end
  endtask

  // driver: pushes the whole expected sequence, then runs the handshake
  task automatic run_seq(input bit rm, input int wake_dly, input bit flip,
                         input int sr_lo, input bit probe);
    exp_t e;
    push_burst(rm, 0, flip);
    e.kind = 1; e.row = row_model; e.gap = 3; e.lo_min = sr_lo; e.lo_max = sr_lo;
    e.cas = 0; e.tg = "R6";
    q.push_back(e);
    push_burst(rm, 2, flip);
    @(negedge clk);
    row_mode = rm; sr_req = 1'b1;
    #1 chk(acc_ready == 1'b0, "R2", int'(acc_ready), 0);
    @(negedge clk);
    sr_req = 1'b0;
    if (flip) row_mode = !rm;
    while (!sr_active) @(negedge clk);
    if (probe) begin
      chk(a_err == 1'b1, "R9", int'(a_err), 1);
      chk(b_err == 1'b0, "R10", int'(b_err), 0);
      chk(err == 1'b0, "R9", int'(err), 0);
    end
    repeat (wake_dly) @(negedge clk);
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    while (!acc_ready) @(negedge clk);
    chk(q.size() == 0, "R7", q.size(), 0);
  endtask

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(0, "R3", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ras_n == 1'b1 && cas_n == 1'b1, "R1", int'({ras_n, cas_n}), 3);
    chk(acc_ready == 1'b1, "R1", int'(acc_ready), 1);
    chk(sr_active == 1'b0 && err == 1'b0, "R1", int'({sr_active, err}), 0);
    chk(row_addr == '0, "R1", int'(row_addr), 0);

    run_seq(1'b0, 0, 1'b0, TR, 1'b1);
    chk(err == 1'b0, "R11", int'(err), 0);
    chk(b_err == 1'b1, "R10", int'(b_err), 1);
    chk(c_err == 1'b1, "R11", int'(c_err), 1);

    run_seq(1'b1, 40, 1'b1, 41, 1'b0);
    chk(a_err == 1'b1, "R12", int'(a_err), 1);

    run_seq(1'b1, 0, 1'b0, TR, 1'b0);
    chk(err == 1'b0, "R9", int'(err), 0);

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(a_err == 1'b0 && b_err == 1'b0 && c_err == 1'b0, "R12",
        int'({a_err, b_err, c_err}), 0);
    chk(row_addr == '0, "R1", int'(row_addr), 0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule